// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the master side of a single-wire serial bus: one data line that is open-drain and held high by an external resistor. The controller only ever pulls the line low or lets it float. It derives a one-microsecond time base from the system clock. From that base it builds timed slots: a bus reset with presence detection, a slot that writes a one, a slot that writes a zero, and a read slot.

A host issues one command at a time:
- a bus reset;
- a byte write;
- a byte read;
- a complete identity read, which returns a 48-bit serial number.

While the command runs, `busy` is high. A single-cycle `done` pulse marks its end, and the results are valid in that cycle. The input from the bus passes through a two-flop synchronizer before it is sampled.

Top module: `swbus_master`

## Requirements
- R1: A bus reset pulls the line low for 480 µs, then releases it for 480 µs. The line is sampled 70 µs after the release. Every interval is a whole number of microseconds, and one microsecond is `CLKS_PER_US` clock cycles.
- R2: After a bus reset, `presenceN` holds the line level that was sampled. A value of 0 means a device answered and 1 means no device was found. Reset sets it to 1, and it changes only during a bus reset.
- R3: A slot that writes a one pulls the line low for 6 µs, then releases it for 64 µs.
- R4: A slot that writes a zero pulls the line low for 60 µs, then releases it for 10 µs.
- R5: A read slot pulls the line low for 6 µs and releases it. The line is sampled 9 µs after the release, and the slot ends 55 µs after the sample.
- R6: The command is selected by `cmdOp`: 0 is a bus reset, 1 writes `cmdData`, 2 reads a byte into `rxData`, and 3 is the identity read. A byte takes eight back-to-back slots and is sent or received least-significant bit first.
- R7: The identity read runs a bus reset and then writes 0x33. It then reads one family byte and discards it, reads six identity bytes, and reads one check byte. The check byte is left in `rxData`.
- R8: `romId[47:40]` holds the first identity byte received and `romId[7:0]` the sixth.
- R9: A command offered while `busy` is high is ignored. The running operation continues unchanged.
- R10: `done` is high for exactly one cycle at the end of each operation. `busy` falls in that same cycle, and the results are valid then.
- R11: The line is driven low only during the low part of a slot, and is otherwise high-impedance. A synchronous reset returns the block to idle with the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command strobe, taken only while idle |
| cmdOp | input | 2 | Command select (see R6) |
| cmdData | input | 8 | Byte to write |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle end-of-operation pulse |
| presenceN | output | 1 | Line level sampled by the last bus reset |
| rxData | output | 8 | Last byte read |
| romId | output | 48 | Serial number from the identity read |
| busLine | inout | 1 | Open-drain bus line |

## Verification
A command accepted at a clock edge raises `busy` at that edge. The operation then lasts exactly the sum of its slot lengths times `CLKS_PER_US` cycles:
- 960 µs for a bus reset;
- 560 µs for a byte;
- 6000 µs for the identity read.

`done` rises at the edge where `busy` falls. A behavioural model in the bench recomputes this countdown from each accepted command and compares `busy` and `done` with it on every falling clock edge. Pulse widths and decoded bits are measured by a bench device model that also samples on falling edges. Read data, presence and the serial number are checked in the cycle where `done` is seen high.

// File: rtl/swbus_pkg.sv
package swbus_pkg;
  localparam int BYTE_W   = 8;
  localparam int ID_BYTES = 6;
  localparam int ID_W     = ID_BYTES * BYTE_W;

  // slot intervals in microseconds
  localparam int RST_LOW_US    = 480;
  localparam int RST_SAMPLE_US = 70;
  localparam int RST_TAIL_US   = 410;
  localparam int W1_LOW_US     = 6;
  localparam int W1_REST_US    = 64;
  localparam int W0_LOW_US     = 60;
  localparam int W0_REST_US    = 10;
  localparam int RD_LOW_US     = 6;
  localparam int RD_SAMPLE_US  = 9;
  localparam int RD_TAIL_US    = 55;

  localparam logic [BYTE_W-1:0] ID_READ_CMD = 8'h33;

  typedef enum logic [1:0] {
    OP_BUS_RESET  = 2'd0,
    OP_WRITE_BYTE = 2'd1,
    OP_READ_BYTE  = 2'd2,
    OP_READ_ID    = 2'd3
  } cmdOp_t;

  typedef enum logic [1:0] {
    SLOT_RESET,
    SLOT_WRITE1,
    SLOT_WRITE0,
    SLOT_READ
  } slotKind_t;

  typedef struct packed {
    logic              active;
    logic              lowPhase;
    slotKind_t         kind;
    logic              clrTimer;
    logic              driveOn;
    logic              driveOff;
    logic              loadTx;
    logic              shiftTx;
    logic              pushId;
    logic [BYTE_W-2:0] txRest;
  } strobes_t;
endpackage

// File: rtl/swbus_sync.sv
module swbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/swbus_timer.sv
module swbus_timer #(
  parameter int CLKS_PER_US = 100,
  parameter int US_W        = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [US_W-1:0] lenM1,
  input  logic [US_W-1:0] sampM1,
  output logic            phaseDone,
  output logic            sampleHit
);
  localparam int CYC_W = $clog2(CLKS_PER_US + 1);

  logic [CYC_W-1:0] cycCnt;
  logic [US_W-1:0]  usCnt;
  logic             tick;

  assign tick = (cycCnt == CYC_W'(CLKS_PER_US - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cycCnt <= '0;
      usCnt  <= '0;
    end else if (tick) begin
      cycCnt <= '0;
      usCnt  <= usCnt + 1'b1;
    end else begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  assign phaseDone = tick && (usCnt == lenM1);
  assign sampleHit = tick && (usCnt == sampM1);
endmodule

// File: rtl/swbus_datapath.sv
module swbus_datapath
  import swbus_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          st,
  input  logic              busIn,
  output logic              driveLow,
  output logic              phaseDone,
  output logic              nextTxBit,
  output logic              presenceN,
  output logic [BYTE_W-1:0] rxData,
  output logic [ID_W-1:0]   romId
);
  localparam int RST_REL_US = RST_SAMPLE_US + RST_TAIL_US;
  localparam int RD_REL_US  = RD_SAMPLE_US + RD_TAIL_US;
  localparam int MAX_US     = (RST_LOW_US > RST_REL_US) ? RST_LOW_US : RST_REL_US;
  localparam int US_W       = $clog2(MAX_US + 1);

  logic              lineS;
  logic              sampleHit;
  int                lowUs, relUs, sampUs;
  logic [US_W-1:0]   lenM1, sampM1;
  logic              driveQ, presQ;
  logic [BYTE_W-2:0] txRestQ;
  logic [BYTE_W-1:0] rxQ;
  logic [ID_W-1:0]   idQ;

  swbus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(busIn), .dout(lineS)
  );

  always_comb begin
    case (st.kind)
      SLOT_RESET:  begin lowUs = RST_LOW_US; relUs = RST_REL_US; sampUs = RST_SAMPLE_US; end
      SLOT_WRITE1: begin lowUs = W1_LOW_US;  relUs = W1_REST_US; sampUs = 1;             end
      SLOT_WRITE0: begin lowUs = W0_LOW_US;  relUs = W0_REST_US; sampUs = 1;             end
      default:     begin lowUs = RD_LOW_US;  relUs = RD_REL_US;  sampUs = RD_SAMPLE_US;  end
    endcase
    lenM1  = US_W'((st.lowPhase ? lowUs : relUs) - 1);
    sampM1 = US_W'(sampUs - 1);
  end

  swbus_timer #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) timer_i (
    .clk(clk), .rst(rst), .clr(st.clrTimer), .lenM1(lenM1), .sampM1(sampM1),
    .phaseDone(phaseDone), .sampleHit(sampleHit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      driveQ  <= 1'b0;
      txRestQ <= '0;
      presQ   <= 1'b1;
      rxQ     <= '0;
      idQ     <= '0;
    end else begin
      if (st.driveOn)       driveQ <= 1'b1;
      else if (st.driveOff) driveQ <= 1'b0;

      if (st.loadTx)       txRestQ <= st.txRest;
      else if (st.shiftTx) txRestQ <= txRestQ >> 1;

      if (st.active && !st.lowPhase && sampleHit) begin
        if (st.kind == SLOT_RESET)     presQ <= lineS;
        else if (st.kind == SLOT_READ) rxQ   <= {lineS, rxQ[BYTE_W-1:1]};
      end

      if (st.pushId) idQ <= {idQ[ID_W-BYTE_W-1:0], rxQ};
    end
  end

  assign driveLow  = driveQ;
  assign nextTxBit = txRestQ[0];
  assign presenceN = presQ;
  assign rxData    = rxQ;
  assign romId     = idQ;
endmodule

// File: rtl/swbus_ctrl.sv
module swbus_ctrl
  import swbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              phaseDone,
  input  logic              nextTxBit,
  output strobes_t          st,
  output logic              busy,
  output logic              done,
  output logic [1:0]        activeOp
);
  localparam int BIT_W         = $clog2(BYTE_W);
  localparam int FIRST_ID_STEP = 3;
  localparam int LAST_STEP     = FIRST_ID_STEP + ID_BYTES;
  localparam int STEP_W        = $clog2(LAST_STEP + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_REL} state_t;

  state_t            stateQ, stateD;
  slotKind_t         kindQ, kindD;
  logic [BIT_W-1:0]  bitQ, bitD;
  logic [STEP_W-1:0] stepQ, stepD;
  logic              idModeQ, idModeD;
  logic [1:0]        opQ, opD;
  logic              doneD;

  always_comb begin
    stateD  = stateQ;
    kindD   = kindQ;
    bitD    = bitQ;
    stepD   = stepQ;
    idModeD = idModeQ;
    opD     = opQ;
    doneD   = 1'b0;
    st          = '0;
    st.active   = (stateQ != S_IDLE);
    st.lowPhase = (stateQ == S_LOW);
    st.kind     = kindQ;

    case (stateQ)
      S_IDLE: begin
        if (cmdValid) begin
          st.clrTimer = 1'b1;
          st.driveOn  = 1'b1;
          stateD      = S_LOW;
          bitD        = '0;
          opD         = cmdOp;
          idModeD     = 1'b0;
          case (cmdOp_t'(cmdOp))
            OP_BUS_RESET:  kindD = SLOT_RESET;
            OP_WRITE_BYTE: begin
              st.loadTx = 1'b1;
              st.txRest = cmdData[BYTE_W-1:1];
              kindD     = cmdData[0] ? SLOT_WRITE1 : SLOT_WRITE0;
            end
            OP_READ_BYTE:  kindD = SLOT_READ;
            default: begin
              kindD   = SLOT_RESET;
              idModeD = 1'b1;
              stepD   = '0;
            end
          endcase
        end
      end

      S_LOW: begin
        if (phaseDone) begin
          st.driveOff = 1'b1;
          st.clrTimer = 1'b1;
          stateD      = S_REL;
        end
      end

      default: begin
        if (phaseDone) begin
          if (kindQ == SLOT_RESET) begin
            if (idModeQ) begin
              st.loadTx = 1'b1;
              st.txRest = ID_READ_CMD[BYTE_W-1:1];
              kindD     = ID_READ_CMD[0] ? SLOT_WRITE1 : SLOT_WRITE0;
              stepD     = STEP_W'(1);
              bitD      = '0;
              st.clrTimer = 1'b1;
              st.driveOn  = 1'b1;
              stateD      = S_LOW;
            end else begin
              stateD = S_IDLE;
              doneD  = 1'b1;
            end
          end else if (bitQ != BIT_W'(BYTE_W - 1)) begin
            bitD        = bitQ + 1'b1;
            st.clrTimer = 1'b1;
            st.driveOn  = 1'b1;
            stateD      = S_LOW;
            if (kindQ != SLOT_READ) begin
              st.shiftTx = 1'b1;
              kindD      = nextTxBit ? SLOT_WRITE1 : SLOT_WRITE0;
            end
          end else begin
            if (idModeQ && stepQ >= STEP_W'(FIRST_ID_STEP) && stepQ < STEP_W'(LAST_STEP))
              st.pushId = 1'b1;
            if (idModeQ && stepQ != STEP_W'(LAST_STEP)) begin
              stepD       = stepQ + 1'b1;
              kindD       = SLOT_READ;
              bitD        = '0;
              st.clrTimer = 1'b1;
              st.driveOn  = 1'b1;
              stateD      = S_LOW;
            end else begin
              stateD = S_IDLE;
              doneD  = 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= S_IDLE;
      kindQ   <= SLOT_RESET;
      bitQ    <= '0;
      stepQ   <= '0;
      idModeQ <= 1'b0;
      opQ     <= '0;
      done    <= 1'b0;
    end else begin
      stateQ  <= stateD;
      kindQ   <= kindD;
      bitQ    <= bitD;
      stepQ   <= stepD;
      idModeQ <= idModeD;
      opQ     <= opD;
      done    <= doneD;
    end
  end

  assign busy     = (stateQ != S_IDLE);
  assign activeOp = opQ;
endmodule

// File: rtl/swbus_master.sv
module swbus_master
  import swbus_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdData,
  output logic              busy,
  output logic              done,
  output logic              presenceN,
  output logic [BYTE_W-1:0] rxData,
  output logic [ID_W-1:0]   romId,
  inout  wire               busLine
);
  strobes_t   st;
  logic       phaseDone;
  logic       nextTxBit;
  logic       lineDrive;
  logic [1:0] activeOp;

  swbus_ctrl ctrl_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .phaseDone(phaseDone), .nextTxBit(nextTxBit), .st(st),
    .busy(busy), .done(done), .activeOp(activeOp)
  );

  swbus_datapath #(.CLKS_PER_US(CLKS_PER_US), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst(rst), .st(st), .busIn(busLine), .driveLow(lineDrive),
    .phaseDone(phaseDone), .nextTxBit(nextTxBit), .presenceN(presenceN),
    .rxData(rxData), .romId(romId)
  );

  assign busLine = lineDrive ? 1'b0 : 1'bz;
endmodule

// File: rtl/swbus_master_chk.sv
module swbus_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       presenceN,
  input logic       lineDrive,
  input logic [1:0] activeOp
);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);

  assert_release_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lineDrive);

  assert_op_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(activeOp));

  assert_presence_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(presenceN));
endmodule

bind swbus_master swbus_master_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .presenceN(presenceN), .lineDrive(lineDrive), .activeOp(activeOp)
);

// File: tb/swbus_master_tb.sv
module swbus_master_tb_top;
  localparam int CPU = 4;
  localparam int HOLD_US = 30;
  localparam int PRES_START_US = 65;
  localparam int PRES_LEN_US = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [7:0]  cmdData = 8'h00;
  logic        busy, done, presenceN;
  logic [7:0]  rxData;
  logic [47:0] romId;
  wire         busLine;
  logic        devLow = 1'b0;

  pullup (busLine);
  assign busLine = devLow ? 1'b0 : 1'bz;

  always #5 clk = ~clk;

  swbus_master #(.CLKS_PER_US(CPU)) dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .busy(busy), .done(done), .presenceN(presenceN), .rxData(rxData),
    .romId(romId), .busLine(busLine)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model of busy/done ----------------
  int mRem = 0;
  bit mDone = 0;

  function automatic int durCycles(input logic [1:0] op);
    case (op)
      2'd0:    return 960 * CPU;
      2'd1:    return 560 * CPU;
      2'd2:    return 560 * CPU;
      default: return (960 + 9 * 560) * CPU;
    endcase
  endfunction

  always @(posedge clk) begin
    mDone = 0;
    if (rst) mRem = 0;
    else if (mRem == 0 && cmdValid) mRem = durCycles(cmdOp);
    else if (mRem > 0) begin
      mRem--;
      if (mRem == 0) mDone = 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst && !finished) begin
      check(busy == (mRem > 0), "R9 busy vs model", busy, mRem > 0);
      check(done == mDone, "R10 done vs model", done, mDone);
    end
    if (cycles > 190000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- bus device model ----------------
  bit devPresent = 1;
  int devMode = 0;
  bit txQ[$];
  int widthQ[$];
  bit [7:0] rxSh = 0;
  bit [7:0] lastRx = 0;
  int rxCnt = 0;
  int lowCnt = 0;
  bit selfLow = 0;
  bit prevLine = 1;
  int holdCnt = 0;
  int presWait = 0;
  int presCnt = 0;
  logic [7:0] idBytes [8] = '{8'h01, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'hE7};

  task automatic loadByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) txQ.push_back(b[i]);
  endtask

  always @(negedge clk) begin
    logic lineNow;
    lineNow = busLine;
    if (lineNow == 1'b0) begin
      if (prevLine) begin
        lowCnt = 0;
        selfLow = 0;
        if (devMode == 1 && txQ.size() > 0) begin
          if (txQ.pop_front() == 1'b0) holdCnt = HOLD_US * CPU;
        end
      end
      lowCnt++;
      if (devLow) selfLow = 1;
    end else if (!prevLine && !selfLow) begin
      widthQ.push_back(lowCnt);
      if (lowCnt >= 300 * CPU) begin
        devMode = 0;
        rxCnt = 0;
        if (devPresent) presWait = PRES_START_US * CPU;
      end else if (devMode == 0) begin
        rxSh = {lowCnt < 15 * CPU, rxSh[7:1]};
        rxCnt++;
        if (rxCnt == 8) begin
          lastRx = rxSh;
          rxCnt = 0;
          if (rxSh == 8'h33) begin
            for (int k = 0; k < 8; k++) loadByte(idBytes[k]);
            devMode = 1;
          end
        end
      end
    end
    prevLine = lineNow;
    if (holdCnt > 0) holdCnt--;
    if (presWait > 0) begin
      presWait--;
      if (presWait == 0) presCnt = PRES_LEN_US * CPU;
    end else if (presCnt > 0) presCnt--;
    devLow <= (holdCnt > 0) || (presCnt > 0);
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [1:0] op, input logic [7:0] data);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp = op;
    cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, tag, done, 1);
  endtask

  initial begin
    logic [7:0] wexp [8];
    int wbits [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R11 reset busy", busy, 0);
    check(done == 0, "R11 reset done", done, 0);
    check(busLine == 1'b1, "R11 line released at reset", busLine, 1);
    check(presenceN == 1, "R2 presence reset value", presenceN, 1);

    // R1 R2: bus reset, device present
    widthQ.delete();
    devPresent = 1;
    issue(2'd0, 8'h00);
    waitDone("R1 reset completes");
    check(presenceN == 0, "R2 device answered", presenceN, 0);
    check(widthQ.size() >= 1 && widthQ[0] == 480 * CPU, "R1 reset low width",
          widthQ.size() >= 1 ? widthQ[0] : -1, 480 * CPU);
    check(busLine == 1'b1, "R11 line released after reset", busLine, 1);
    @(negedge clk);
    check(done == 0, "R10 done single cycle", done, 0);

    // R2: bus reset, no device
    devPresent = 0;
    issue(2'd0, 8'h00);
    waitDone("R1 reset completes, no device");
    check(presenceN == 1, "R2 no device", presenceN, 1);
    devPresent = 1;

    // R3 R4 R6: write 0xA5 (bits LSB first 1,0,1,0,0,1,0,1)
    widthQ.delete();
    devMode = 0; rxCnt = 0;
    issue(2'd1, 8'hA5);
    waitDone("R6 write completes");
    check(lastRx == 8'hA5, "R6 write byte LSB first", lastRx, 8'hA5);
    wbits = '{1, 0, 1, 0, 0, 1, 0, 1};
    for (int i = 0; i < 8; i++) begin
      int expW;
      expW = wbits[i] ? 6 * CPU : 60 * CPU;
      check(widthQ.size() > i && widthQ[i] == expW,
            wbits[i] ? "R3 write-1 low width" : "R4 write-0 low width",
            widthQ.size() > i ? widthQ[i] : -1, expW);
    end

    // R5 R6: read 0x3C and 0x81
    wexp = '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    for (int j = 0; j < 3; j++) begin
      txQ.delete();
      loadByte(wexp[j]);
      devMode = 1;
      issue(2'd2, 8'h00);
      waitDone("R5 read completes");
      check(rxData == wexp[j], "R5 read byte LSB first (R6)", rxData, wexp[j]);
    end
    devMode = 0; rxCnt = 0; txQ.delete();

    // R9: command while busy is ignored
    widthQ.delete();
    issue(2'd1, 8'h0F);
    repeat (50) @(negedge clk);
    issue(2'd3, 8'hFF);
    waitDone("R9 original write completes");
    check(lastRx == 8'h0F, "R9 running write unchanged", lastRx, 8'h0F);
    check(widthQ.size() == 8, "R9 no extra slots", widthQ.size(), 8);

    // R7 R8: identity read
    devMode = 0; rxCnt = 0;
    issue(2'd3, 8'h00);
    waitDone("R7 identity read completes");
    check(lastRx == 8'h33, "R7 command byte sent", lastRx, 8'h33);
    check(romId == 48'h112233445566, "R8 serial number order", romId, 48'h112233445566);
    check(rxData == 8'hE7, "R7 check byte in rxData", rxData, 8'hE7);
    check(presenceN == 0, "R7 presence from reset step", presenceN, 0);

    // R11: synchronous reset mid-operation
    txQ.delete();
    devMode = 1;
    issue(2'd2, 8'h00);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R11 sync reset idles", busy, 0);
    check(busLine == 1'b1, "R11 sync reset releases line", busLine, 1);
    repeat (20) @(negedge clk);
    check(done == 0 && busy == 0, "R11 stays idle", {done, busy}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule